// File: doc/BRIEF.md
# Period-List Playback DMA Sequencer

This block plays out a circular audio buffer that is split into periods. The buffer is not one contiguous region. Software places a list of descriptors in memory, one 8-byte descriptor per period. The first 32-bit word of a descriptor is the byte address of the period. The second word carries the period length in bytes in its upper 16 bits. The sequencer walks this list entry by entry. For each period it reads the descriptor and then fetches the period's sample words one at a time over a simple request/response memory port. Each fetched word is held in a one-word buffer until the output side takes it with a consume strobe.

While the sequencer walks the buffer it keeps its position as a list offset and an in-period byte offset. It raises events when the offset reaches the middle and the end of a period, when it finishes the period that closes the first half of the buffer, and when it finishes the last period. It also raises an event when it reaches a programmed stop offset, and when the output side asks for data that has not arrived yet. Each event sets a sticky status bit. An interrupt line is driven whenever a set status bit is also enabled in a mask.

The sequencer has five states. S_IDLE waits for the channel's start bit. S_DESC_A reads the period-address word. S_DESC_L reads the length word. S_DATA reads one sample word. S_HOLD presents that word and waits for it to be consumed. The transitions are:
- S_IDLE to S_DESC_A when start is set.
- S_DESC_A to S_DESC_L on a response.
- S_DESC_L to S_DATA on a response.
- S_DATA to S_HOLD on a response.
- S_HOLD to S_DATA on a consume inside the period.
- S_HOLD to S_DESC_A on a consume that ends the period.
- S_HOLD to S_IDLE on a consume that reaches the stop offset, or when start is cleared.
- Any request state to S_IDLE when its response arrives after start has been cleared.

Top module: `period_dma_seq`

## Requirements
- R1: After reset the following are all zero: mem_req, smp_valid, list_pos, per_pos, evt_status and irq.
- R2: When the start bit is set, the block reads the word at list base plus list_pos (the period address), then the word 4 bytes above it (length in bits [31:16]). mem_addr holds steady while a request waits for its response.
- R3: Sample words are read from the period address plus per_pos. smp_data is the fetched word. Each consume advances per_pos by 4, and a new word is requested only after the held word is taken.
- R4: The list-size register (address 1) holds, in bits [21:16], the byte offset of the last descriptor, so N periods are written as (N-1)*8. When a period ends, list_pos advances by 8, and it wraps to 0 after the last descriptor.
- R5: Status bit 0 sets when a consume brings the in-period offset to half the period length. Bit 4 sets when it reaches the full length, which is the end of the period; per_pos then returns to 0.
- R6: Status bit 8 sets at the end of period index N/2-1. Bit 12 sets at the end of the last period.
- R7: The end register (address 4) holds a stop offset in bits [15:0] and an enable in bit 16. With the enable set, a consume that brings the in-period offset to the stop offset sets status bit 24, clears the start bit and returns the block to S_IDLE, with no further requests. With the enable clear, the offset is ignored.
- R8: A consume strobe while the block is active but holds no word sets status bit 30 if the current period index is below N/2, otherwise bit 31.
- R9: Writing the status register (address 7) clears the bits written as 1 and leaves the others. The mask sits at address 6. irq is high exactly when status AND mask is nonzero.
- R10: Writes to list_pos (address 2, bits [5:3] kept) and per_pos (address 3) take effect only in S_IDLE; while the block is running they are ignored.
- R11: The control register (address 5) holds one start bit per channel in bits [3:0]. Only bit CHAN_ID starts this block, and clearing it stops the block; the other bits have no effect. List base is address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory read request, held until response |
| mem_addr | output | AW | Byte address of the read |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| smp_data | output | 32 | Held sample word |
| smp_valid | output | 1 | Sample word available |
| smp_take | input | 1 | Consume strobe from the output side |
| list_pos | output | LPW | Byte offset of the current descriptor |
| per_pos | output | PW | Byte offset within the current period |
| evt_status | output | 32 | Sticky event status |
| irq | output | 1 | Interrupt line |

## Verification
The bench targets these corner cases:
- The list wrap after the last descriptor with 2, 4 and 8 periods. A wrong wrap shows up as sample data read from the wrong period.
- The coincidence of the half-period offset with a stop offset. A design that checks only one of them on the same consume would miss a status bit.
- A consume that arrives while a fetch is still in flight. If the design treats it as a take, the offset skips a word. If it ignores it, the xrun bit stays clear.
- Position writes made during play. A design that accepts them jumps to a different period.
- Start bits that belong to other channels. A design that decodes them wrongly would begin issuing requests.

// File: rtl/pds_pkg.sv
package pds_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DESC_A,
        S_DESC_L,
        S_DATA,
        S_HOLD
    } walk_t;

    localparam logic [2:0] RA_LBASE  = 3'd0;
    localparam logic [2:0] RA_LSIZE  = 3'd1;
    localparam logic [2:0] RA_LPTR   = 3'd2;
    localparam logic [2:0] RA_PPTR   = 3'd3;
    localparam logic [2:0] RA_ENDCTL = 3'd4;
    localparam logic [2:0] RA_CTRL   = 3'd5;
    localparam logic [2:0] RA_MASK   = 3'd6;
    localparam logic [2:0] RA_STAT   = 3'd7;

    localparam int B_HPER = 0;
    localparam int B_FPER = 4;
    localparam int B_HBUF = 8;
    localparam int B_FBUF = 12;
    localparam int B_END  = 24;
    localparam int B_XR_H = 30;
    localparam int B_XR_F = 31;

    typedef struct packed {
        logic xr_f;
        logic xr_h;
        logic end_hit;
        logic fbuf;
        logic hbuf;
        logic fper;
        logic hper;
    } evt_t;

endpackage

// File: rtl/pds_cfg.sv
module pds_cfg
    import pds_pkg::*;
#(
    parameter int AW      = 32,
    parameter int LPW     = 6,
    parameter int PW      = 16,
    parameter int NCH     = 4,
    parameter int CHAN_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              stop_clr,
    output logic [AW-1:0]     list_base,
    output logic [LPW-4:0]    last_idx,
    output logic [PW-1:0]     end_off,
    output logic              end_flag,
    output logic              run
);
    localparam int IW = LPW - 3;

    logic [LPW-1:0] lsize_q;
    logic [NCH-1:0] ctrl_q, ctrl_n;
    logic [AW-1:0]  base_q;
    logic [PW-1:0]  eoff_q;
    logic           eflag_q;

    always_comb begin
        ctrl_n = ctrl_q;
        if (wr_en && wr_addr == RA_CTRL)
            ctrl_n = wr_data[NCH-1:0];
        if (stop_clr)
            ctrl_n[CHAN_ID] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            lsize_q <= '0;
            eoff_q  <= '0;
            eflag_q <= 1'b0;
            ctrl_q  <= '0;
        end else begin
            ctrl_q <= ctrl_n;
            if (wr_en) begin
                unique case (wr_addr)
                    RA_LBASE:  base_q  <= wr_data[AW-1:0];
                    RA_LSIZE:  lsize_q <= wr_data[16 +: LPW];
                    RA_ENDCTL: begin
                        eoff_q  <= wr_data[PW-1:0];
                        eflag_q <= wr_data[16];
                    end
                    default: ;
                endcase
            end
        end
    end

    assign list_base = base_q;
    assign last_idx  = lsize_q[LPW-1:3];
    assign end_off   = eoff_q;
    assign end_flag  = eflag_q;
    assign run       = ctrl_q[CHAN_ID];

    logic unused_cfg;
    assign unused_cfg = ^{lsize_q[2:0], IW[0]};

endmodule

// File: rtl/pds_walker.sv
module pds_walker
    import pds_pkg::*;
#(
    parameter int AW  = 32,
    parameter int LPW = 6,
    parameter int PW  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [AW-1:0]   list_base,
    input  logic [LPW-4:0]  last_idx,
    input  logic [PW-1:0]   end_off,
    input  logic            end_flag,
    input  logic            wr_en,
    input  logic [2:0]      wr_addr,
    input  logic [31:0]     wr_data,
    output logic            mem_req,
    output logic [AW-1:0]   mem_addr,
    input  logic            mem_rvalid,
    input  logic [31:0]     mem_rdata,
    output logic [31:0]     smp_data,
    output logic            smp_valid,
    input  logic            smp_take,
    output logic [LPW-1:0]  list_pos,
    output logic [PW-1:0]   per_pos,
    output evt_t            ev,
    output logic            stop_clr
);
    localparam int IW = LPW - 3;
    localparam logic [PW-1:0]  STEP  = PW'(4);
    localparam logic [LPW-1:0] LSTEP = LPW'(8);

    walk_t state, state_n;

    logic [AW-1:0]  addr_q, addr_n, per_addr_q, per_addr_n;
    logic [PW-1:0]  per_len_q, pos_q, pos_n, off_nxt;
    logic [LPW-1:0] lpos_q, lpos_n;
    logic [31:0]    buf_q;
    logic           buf_v;
    logic [IW-1:0]  idx;
    logic [IW:0]    ents, half;
    logic           take_ok, at_half, at_full, hit_end;
    logic           first_half, is_last, is_hb, idle_wr, active;

    assign idx        = lpos_q[LPW-1:3];
    assign ents       = {1'b0, last_idx} + 1'b1;
    assign half       = ents >> 1;
    assign first_half = {1'b0, idx} < half;
    assign is_last    = idx == last_idx;
    assign is_hb      = ({1'b0, idx} + 1'b1) == half;
    assign off_nxt    = pos_q + STEP;
    assign at_half    = off_nxt == (per_len_q >> 1);
    assign at_full    = off_nxt == per_len_q;
    assign hit_end    = end_flag && (off_nxt == end_off);
    assign take_ok    = (state == S_HOLD) && run && smp_take;
    assign idle_wr    = (state == S_IDLE) && wr_en;
    assign active     = (state != S_IDLE) && (state != S_HOLD);

    // next-state decision
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:   if (run) state_n = S_DESC_A;
            S_DESC_A: if (mem_rvalid) state_n = run ? S_DESC_L : S_IDLE;
            S_DESC_L: if (mem_rvalid) state_n = run ? S_DATA : S_IDLE;
            S_DATA:   if (mem_rvalid) state_n = run ? S_HOLD : S_IDLE;
            S_HOLD: begin
                if (!run)
                    state_n = S_IDLE;
                else if (smp_take) begin
                    if (hit_end)      state_n = S_IDLE;
                    else if (at_full) state_n = S_DESC_A;
                    else              state_n = S_DATA;
                end
            end
            default: state_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // position and address bookkeeping
    always_comb begin
        lpos_n = lpos_q;
        pos_n  = pos_q;
        if (idle_wr && wr_addr == RA_LPTR)
            lpos_n = {wr_data[LPW-1:3], 3'b000};
        if (idle_wr && wr_addr == RA_PPTR)
            pos_n = wr_data[PW-1:0];
        if (take_ok) begin
            if (at_full) begin
                pos_n  = '0;
                lpos_n = is_last ? '0 : lpos_q + LSTEP;
            end else begin
                pos_n = off_nxt;
            end
        end
    end

    always_comb begin
        per_addr_n = per_addr_q;
        if (state == S_DESC_A && mem_rvalid)
            per_addr_n = mem_rdata[AW-1:0];
    end

    always_comb begin
        addr_n = addr_q;
        if (state_n != state) begin
            unique case (state_n)
                S_DESC_A: addr_n = list_base + AW'(lpos_n);
                S_DESC_L: addr_n = addr_q + AW'(4);
                S_DATA:   addr_n = per_addr_n + AW'(pos_n);
                default:  addr_n = addr_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q     <= '0;
            per_addr_q <= '0;
            per_len_q  <= '0;
            pos_q      <= '0;
            lpos_q     <= '0;
            buf_q      <= '0;
            buf_v      <= 1'b0;
        end else begin
            addr_q     <= addr_n;
            per_addr_q <= per_addr_n;
            pos_q      <= pos_n;
            lpos_q     <= lpos_n;
            if (state == S_DESC_L && mem_rvalid)
                per_len_q <= mem_rdata[31 -: PW];
            if (state == S_DATA && mem_rvalid && run) begin
                buf_q <= mem_rdata;
                buf_v <= 1'b1;
            end else if (take_ok || state_n == S_IDLE) begin
                buf_v <= 1'b0;
            end
        end
    end

    // outputs and event pulses
    always_comb begin
        mem_req    = (state == S_DESC_A) || (state == S_DESC_L) || (state == S_DATA);
        mem_addr   = addr_q;
        smp_data   = buf_q;
        smp_valid  = buf_v;
        list_pos   = lpos_q;
        per_pos    = pos_q;
        ev         = '0;
        ev.hper    = take_ok && at_half;
        ev.fper    = take_ok && at_full;
        ev.hbuf    = take_ok && at_full && is_hb;
        ev.fbuf    = take_ok && at_full && is_last;
        ev.end_hit = take_ok && hit_end;
        ev.xr_h    = smp_take && active && first_half;
        ev.xr_f    = smp_take && active && !first_half;
        stop_clr   = ev.end_hit;
    end

    a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    a_r3_no_req_with_data: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> !mem_req);

    a_r5_period_restart: assert property (@(posedge clk) disable iff (!rst_n)
        ev.fper |=> (per_pos == '0));

    a_r4_list_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ev.fbuf |=> (list_pos == '0));

    a_r7_end_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ev.end_hit |=> (!mem_req && !smp_valid));

endmodule

// File: rtl/pds_irq.sv
module pds_irq
    import pds_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  evt_t        ev,
    output logic [31:0] status,
    output logic        irq
);
    logic [31:0] mask_q, stat_q, set_v, clr_v;

    always_comb begin
        set_v         = '0;
        set_v[B_HPER] = ev.hper;
        set_v[B_FPER] = ev.fper;
        set_v[B_HBUF] = ev.hbuf;
        set_v[B_FBUF] = ev.fbuf;
        set_v[B_END]  = ev.end_hit;
        set_v[B_XR_H] = ev.xr_h;
        set_v[B_XR_F] = ev.xr_f;
        clr_v = (wr_en && wr_addr == RA_STAT) ? wr_data : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            stat_q <= '0;
        end else begin
            if (wr_en && wr_addr == RA_MASK)
                mask_q <= wr_data;
            stat_q <= (stat_q & ~clr_v) | set_v;
        end
    end

    always_comb begin
        status = stat_q;
        irq    = |(stat_q & mask_q);
    end

    a_r8_xrun_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev.xr_h && ev.xr_f));

    a_r9_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RA_STAT && wr_data == 32'hFFFF_FFFF && set_v == '0)
        |=> (status == '0));

    a_r9_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != '0));

endmodule

// File: rtl/period_dma_seq.sv
module period_dma_seq
    import pds_pkg::*;
#(
    parameter int AW      = 32,
    parameter int LPW     = 6,
    parameter int PW      = 16,
    parameter int NCH     = 4,
    parameter int CHAN_ID = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic [2:0]      cfg_addr,
    input  logic [31:0]     cfg_wdata,
    output logic            mem_req,
    output logic [AW-1:0]   mem_addr,
    input  logic            mem_rvalid,
    input  logic [31:0]     mem_rdata,
    output logic [31:0]     smp_data,
    output logic            smp_valid,
    input  logic            smp_take,
    output logic [LPW-1:0]  list_pos,
    output logic [PW-1:0]   per_pos,
    output logic [31:0]     evt_status,
    output logic            irq
);
    logic [AW-1:0]  list_base;
    logic [LPW-4:0] last_idx;
    logic [PW-1:0]  end_off;
    logic           end_flag, run, stop_clr;
    evt_t           ev;

    pds_cfg #(
        .AW(AW), .LPW(LPW), .PW(PW), .NCH(NCH), .CHAN_ID(CHAN_ID)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_wr), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
        .stop_clr(stop_clr),
        .list_base(list_base), .last_idx(last_idx),
        .end_off(end_off), .end_flag(end_flag), .run(run)
    );

    pds_walker #(
        .AW(AW), .LPW(LPW), .PW(PW)
    ) u_walk (
        .clk(clk), .rst_n(rst_n), .run(run),
        .list_base(list_base), .last_idx(last_idx),
        .end_off(end_off), .end_flag(end_flag),
        .wr_en(cfg_wr), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .smp_data(smp_data), .smp_valid(smp_valid), .smp_take(smp_take),
        .list_pos(list_pos), .per_pos(per_pos),
        .ev(ev), .stop_clr(stop_clr)
    );

    pds_irq u_irq (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_wr), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
        .ev(ev), .status(evt_status), .irq(irq)
    );

endmodule

// File: tb/period_dma_seq_bench.sv
module period_dma_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] smp_data;
    logic        smp_valid;
    logic        smp_take = 1'b0;
    logic [5:0]  list_pos;
    logic [15:0] per_pos;
    logic [31:0] evt_status;
    logic        irq;

    always #4 clk = ~clk;

    period_dma_seq u_period_dma_seq (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .smp_data(smp_data), .smp_valid(smp_valid), .smp_take(smp_take),
        .list_pos(list_pos), .per_pos(per_pos),
        .evt_status(evt_status), .irq(irq)
    );

    localparam logic [31:0] LBASE = 32'h100;

    int          n_chk = 0;
    int          n_bad = 0;
    bit          done  = 0;
    logic [31:0] dlist [0:15];
    int          m_len  [0:7];
    int          m_addr [0:7];
    int          m_idx, m_off, m_ents, m_endo;
    bit          m_endf;
    logic [31:0] m_mask, exp_stat;
    int          lat = 0;

    function automatic logic [31:0] sample_of(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, a[15:0]};
    endfunction

    function automatic logic [31:0] mem_read(input logic [31:0] a);
        if (a >= LBASE && a < LBASE + 32'h40) return dlist[(a - LBASE) >> 2];
        return sample_of(a);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory responder with 1..3 cycle latency
    initial begin
        forever begin
            @(negedge clk);
            if (mem_rvalid) mem_rvalid = 1'b0;
            else if (mem_req) begin
                if (lat == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = mem_read(mem_addr);
                    lat = $urandom % 3;
                end else lat--;
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic setup(input int ents, input logic [31:0] endctl);
        for (int i = 0; i < ents; i++) begin
            m_len[i]  = 64 * (1 + ($urandom % 2));
            m_addr[i] = 32'h1000 + i * 32'h400 + ($urandom % 4) * 32'h40;
            dlist[2*i]   = m_addr[i];
            dlist[2*i+1] = m_len[i] << 16;
        end
        m_ents = ents; m_idx = 0; m_off = 0;
        m_endf = endctl[16]; m_endo = endctl[15:0];
        wr(3'd0, LBASE);
        wr(3'd1, ((ents - 1) * 8) << 16);
        wr(3'd2, 0);
        wr(3'd3, 0);
        wr(3'd4, endctl);
        m_mask = $urandom & 32'hC100_1111;
        wr(3'd6, m_mask);
        wr(3'd7, 32'hFFFF_FFFF);
        exp_stat = 0;
    endtask

    task automatic consume();
        int w;
        int noff;
        logic [31:0] ev;
        w = 0;
        while (!smp_valid && w < 60) begin @(negedge clk); w++; end
        if (!smp_valid) begin chk("R3 sample never valid", 0, 1); return; end
        chk("R3 sample data", smp_data, sample_of(m_addr[m_idx] + m_off));
        smp_take = 1'b1;
        @(negedge clk);
        smp_take = 1'b0;
        ev = 0;
        noff = m_off + 4;
        if (noff == m_len[m_idx] / 2) ev[0] = 1'b1;
        if (m_endf && noff == m_endo) ev[24] = 1'b1;
        if (noff == m_len[m_idx]) begin
            ev[4] = 1'b1;
            if (m_idx == m_ents / 2 - 1) ev[8] = 1'b1;
            if (m_idx == m_ents - 1) ev[12] = 1'b1;
            m_off = 0;
            m_idx = (m_idx == m_ents - 1) ? 0 : m_idx + 1;
        end else m_off = noff;
        exp_stat |= ev;
        chk("R5 R6 R7 status", evt_status, exp_stat);
        chk("R4 list position", {26'd0, list_pos}, m_idx * 8);
        chk("R3 period position", {16'd0, per_pos}, m_off);
        chk("R9 irq", {31'd0, irq}, {31'd0, |(exp_stat & m_mask)});
    endtask

    task automatic run_words(input int n);
        for (int k = 0; k < n; k++) begin
            repeat ($urandom % 3) @(negedge clk);
            if (($urandom % 8) == 0) begin
                logic [31:0] c;
                c = $urandom;
                wr(3'd7, c);
                exp_stat &= ~c;
                chk("R9 partial clear", evt_status, exp_stat);
            end
            consume();
        end
    endtask

    task automatic stop_run();
        wr(3'd5, 0);
        repeat (10) @(negedge clk);
    endtask

    function automatic int buf_words();
        int s = 0;
        for (int i = 0; i < m_ents; i++) s += m_len[i] / 4;
        return s;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 mem_req", {31'd0, mem_req}, 0);
        chk("R1 smp_valid", {31'd0, smp_valid}, 0);
        chk("R1 list_pos", {26'd0, list_pos}, 0);
        chk("R1 per_pos", {16'd0, per_pos}, 0);
        chk("R1 status", evt_status, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 other channels' start bits do nothing
        setup(4, 0);
        wr(3'd5, 32'hE);
        repeat (10) begin
            @(negedge clk);
            chk("R11 no request on foreign start", {31'd0, mem_req}, 0);
        end

        // random walk over 4 periods, two buffer rounds
        wr(3'd5, 32'h1);
        run_words(2 * buf_words());

        // R10 position writes ignored while running
        wr(3'd2, 32'h28);
        wr(3'd3, 32'h3C);
        chk("R10 list_pos unchanged while running", {26'd0, list_pos}, m_idx * 8);
        chk("R10 per_pos unchanged while running", {16'd0, per_pos}, m_off);

        // R8 xrun: consume while the next word is in flight
        consume();
        smp_take = 1'b1;
        chk("R8 no word held after take", {31'd0, smp_valid}, 0);
        @(negedge clk);
        smp_take = 1'b0;
        if (m_idx < m_ents / 2) exp_stat[30] = 1'b1; else exp_stat[31] = 1'b1;
        chk("R8 xrun status", evt_status, exp_stat);
        consume();

        // R11 clearing start stops, then R10 loads in idle
        stop_run();
        chk("R11 stopped no request", {31'd0, mem_req}, 0);
        wr(3'd2, 32'h10);
        wr(3'd3, 32'h20);
        chk("R10 list_pos loaded in idle", {26'd0, list_pos}, 32'h10);
        chk("R10 per_pos loaded in idle", {16'd0, per_pos}, 32'h20);
        m_idx = 2; m_off = 32'h20;
        wr(3'd5, 32'h1);
        run_words(12);
        // R8 second half xrun
        while (m_idx < m_ents / 2) consume();
        smp_take = 1'b1;
        @(negedge clk);
        smp_take = 1'b0;
        exp_stat[31] = 1'b1;
        chk("R8 second-half xrun", evt_status, exp_stat);
        consume();
        stop_run();

        // 2 and 8 period buffers, R4 wrap and R6 buffer events
        setup(2, 0);
        wr(3'd5, 32'h1);
        run_words(buf_words() + 3);
        stop_run();
        setup(8, 0);
        wr(3'd5, 32'h1);
        run_words(buf_words() + 3);
        stop_run();

        // R9 directed W1C on chosen bits
        exp_stat = evt_status;
        wr(3'd7, 32'h0000_1010);
        exp_stat &= ~32'h0000_1010;
        chk("R9 directed clear", evt_status, exp_stat);

        // R7 end offset stop, coinciding with half period when length is 64
        setup(2, 32'h0001_0020);
        wr(3'd5, 32'h1);
        for (int k = 0; k < 8; k++) consume();
        chk("R7 end bit", {31'd0, evt_status[24]}, 1);
        repeat (10) begin
            @(negedge clk);
            chk("R7 no request after stop", {31'd0, mem_req}, 0);
        end
        chk("R7 no data after stop", {31'd0, smp_valid}, 0);
        chk("R7 offset held", {16'd0, per_pos}, 32'h20);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule